// File: doc/BRIEF.md
# Two-Class Steerable Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests and turns them into two processor request lines. One line is for fast, high-priority service and the other for ordinary service. Software steers every source to exactly one of the two lines with a per-source class bit, and a per-source enable bit masks it in or out. The ordinary line has the lower priority. The processor side may let a fast request preempt an ordinary handler, so the two lines are produced independently and can be active at the same time.

Servicing works in two tiers. The handler first reads the class-specific pending register to learn which module raised the request. It then asks that module for the exact event. In this block each module, including each general-purpose pin set up as an interrupt source, appears as one aggregated request line. A registered wake output is also provided. Depending on a mode bit, it follows either any enabled pending source or only sources marked in a separate wake-enable register, regardless of the enable mask.

A simple register port gives write and read access. Writes take effect on a clock edge. Reads are combinational.

Top module: `dual_class_intc`

## Requirements
- R1: After reset, the enable, class, wake-enable and mode registers read as zero, so every source starts disabled and steered to the ordinary line. The fastReq, normReq and wakeReq outputs are low.
- R2: A write with wrEn high stores wrData at the addressed register. The addresses are: 0 = enable (1 enables a source), 1 = class (1 selects the fast line, 0 the ordinary line), 2 = wake-enable, 6 = mode (bit 0 only). Each of these reads back what was written, and the mode register reads as zero in bits above 0.
- R3: Address 3 reads the raw source levels, whatever the enable bits hold.
- R4: Address 4 reads the sources that are active, enabled and in the fast class. Address 5 reads those that are active, enabled and in the ordinary class.
- R5: fastReq is the OR of the address-4 set and normReq is the OR of the address-5 set. Each is registered, so it changes on the first clock edge after its inputs change.
- R6: An active source whose enable bit is 0 raises neither request line and shows in neither class-pending register.
- R7: Changing a source's class bit moves its request from one line to the other. A single active source never drives both lines.
- R8: With mode bit 0 clear, wakeReq is the registered OR of all enabled active sources. With mode bit 0 set, wakeReq is the registered OR of active sources whose wake-enable bit is 1, regardless of the enable bits.
- R9: Writes to addresses 3, 4, 5 and 7 change no register.
- R10: Address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcReq | input | NUM_SRC | Level-sensitive request from each source module |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | NUM_SRC | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | NUM_SRC | Combinational register read data |
| fastReq | output | 1 | Registered high-priority request to the processor |
| normReq | output | 1 | Registered low-priority request to the processor |
| wakeReq | output | 1 | Registered wake request |

## Verification
Every cycle, the assertions check the following. The raw read tracks the inputs. The class-pending reads never show a source that is idle. A write to the enable register is visible on the next read. All three outputs fall one edge after every source goes quiet. A request line never rises without a source having been active on the edge before. Only the directed scenarios can show the rest: the exact split between the two lines under different class settings, masking, moving a source between classes, the two wake modes, and the fact that writes to read-only addresses are ignored.

// File: rtl/dual_class_intc_pkg.sv
package dual_class_intc_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_ENABLE = 3'd0,
    ADDR_CLASS  = 3'd1,
    ADDR_WAKEEN = 3'd2,
    ADDR_RAW    = 3'd3,
    ADDR_FPEND  = 3'd4,
    ADDR_NPEND  = 3'd5,
    ADDR_MODE   = 3'd6,
    ADDR_SPARE  = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic wrEnable;
    logic wrClass;
    logic wrWakeEn;
    logic wrMode;
  } wrStrobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import dual_class_intc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strb
);

  regAddr_e addrSel;

  always_comb begin
    addrSel = regAddr_e'(wrAddr);
    strb = '0;
    if (wrEn) begin
      unique case (addrSel)
        ADDR_ENABLE: strb.wrEnable = 1'b1;
        ADDR_CLASS:  strb.wrClass  = 1'b1;
        ADDR_WAKEEN: strb.wrWakeEn = 1'b1;
        ADDR_MODE:   strb.wrMode   = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/intc_dpath.sv
module intc_dpath
  import dual_class_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wrStrobe_t          strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic               fastReq,
  output logic               normReq,
  output logic               wakeReq
);

  logic [NUM_SRC-1:0] enableQ, classQ, wakeEnQ;
  logic               modeQ;
  logic [NUM_SRC-1:0] fastPend, normPend, wakePend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableQ <= '0;
      classQ  <= '0;
      wakeEnQ <= '0;
      modeQ   <= 1'b0;
    end else begin
      if (strb.wrEnable) enableQ <= wrData;
      if (strb.wrClass)  classQ  <= wrData;
      if (strb.wrWakeEn) wakeEnQ <= wrData;
      if (strb.wrMode)   modeQ   <= wrData[0];
    end
  end

  // Per-source split into the two classes and the wake candidate
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    assign live        = srcReq[i] & enableQ[i];
    assign fastPend[i] = live & classQ[i];
    assign normPend[i] = live & ~classQ[i];
    assign wakePend[i] = modeQ ? (srcReq[i] & wakeEnQ[i]) : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fastReq <= 1'b0;
      normReq <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      fastReq <= |fastPend;
      normReq <= |normPend;
      wakeReq <= |wakePend;
    end
  end

  always_comb begin
    unique case (regAddr_e'(rdAddr))
      ADDR_ENABLE: rdData = enableQ;
      ADDR_CLASS:  rdData = classQ;
      ADDR_WAKEEN: rdData = wakeEnQ;
      ADDR_RAW:    rdData = srcReq;
      ADDR_FPEND:  rdData = fastPend;
      ADDR_NPEND:  rdData = normPend;
      ADDR_MODE:   rdData = {{(NUM_SRC-1){1'b0}}, modeQ};
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import dual_class_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [2:0]         rdAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic               fastReq,
  output logic               normReq,
  output logic               wakeReq
);

  wrStrobe_t strb;

  intc_ctrl ctrl_i (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strb   (strb)
  );

  intc_dpath #(.NUM_SRC(NUM_SRC)) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (wrData),
    .srcReq  (srcReq),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .fastReq (fastReq),
    .normReq (normReq),
    .wakeReq (wakeReq)
  );

endmodule

// File: rtl/dual_class_intc_checker.sv
module dual_class_intc_checker #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               wrEn,
  input logic [2:0]         wrAddr,
  input logic [NUM_SRC-1:0] wrData,
  input logic [2:0]         rdAddr,
  input logic [NUM_SRC-1:0] rdData,
  input logic               fastReq,
  input logic               normReq,
  input logic               wakeReq
);

  p_raw_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == 3'd3) |-> (rdData == srcReq));

  p_pend_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == 3'd4 || rdAddr == 3'd5) |-> ((rdData & ~srcReq) == '0));

  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEn) && $past(wrAddr) == 3'd0 && rdAddr == 3'd0) |-> (rdData == $past(wrData)));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srcReq == '0) |=> (!fastReq && !normReq));

  p_wake_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srcReq == '0) |=> !wakeReq);

  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fastReq) || $rose(normReq)) |-> $past(|srcReq));

endmodule

bind dual_class_intc dual_class_intc_checker #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .srcReq  (srcReq),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .rdAddr  (rdAddr),
  .rdData  (rdData),
  .fastReq (fastReq),
  .normReq (normReq),
  .wakeReq (wakeReq)
);

// File: tb/dual_class_intc_tb_top.sv
module dual_class_intc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] srcReq = '0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [N-1:0] rdData;
  logic         fastReq, normReq, wakeReq;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_class_intc #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .fastReq(fastReq), .normReq(normReq), .wakeReq(wakeReq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic outChk(input logic f, input logic n, input string tag);
    chk({tag, " fast"}, {{(N-1){1'b0}}, fastReq}, {{(N-1){1'b0}}, f});
    chk({tag, " norm"}, {{(N-1){1'b0}}, normReq}, {{(N-1){1'b0}}, n});
  endtask

  task automatic t_reset();
    rdChk(3'd0, '0, "R1 enable");
    rdChk(3'd1, '0, "R1 class");
    rdChk(3'd2, '0, "R1 wake-enable");
    rdChk(3'd6, '0, "R1 mode");
    outChk(1'b0, 1'b0, "R1 outputs");
    chk("R1 wake", {{(N-1){1'b0}}, wakeReq}, '0);
  endtask

  task automatic t_regs();
    wr(3'd0, 32'hA5A5_0F0F); rdChk(3'd0, 32'hA5A5_0F0F, "R2 enable");
    wr(3'd1, 32'h1234_8765); rdChk(3'd1, 32'h1234_8765, "R2 class");
    wr(3'd2, 32'h0BAD_F00D); rdChk(3'd2, 32'h0BAD_F00D, "R2 wake-enable");
    wr(3'd6, 32'hFFFF_FFFF); rdChk(3'd6, 32'h1, "R2 mode");
    wr(3'd6, 32'h0); rdChk(3'd6, 32'h0, "R2 mode clear");
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0);
  endtask

  task automatic t_raw();
    srcReq = 32'h1234_5678;
    settle();
    rdChk(3'd3, 32'h1234_5678, "R3 raw while disabled");
    rdChk(3'd4, '0, "R6 fast pending disabled");
    rdChk(3'd5, '0, "R6 norm pending disabled");
    outChk(1'b0, 1'b0, "R6 all disabled");
    srcReq = '0;
    settle();
  endtask

  task automatic t_route();
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_FFFF);
    srcReq = 32'h0001_0001;
    settle();
    rdChk(3'd4, 32'h0000_0001, "R4 fast pending");
    rdChk(3'd5, 32'h0001_0000, "R4 norm pending");
    outChk(1'b1, 1'b1, "R5 both lines");
    srcReq = 32'h0000_0002;
    settle();
    outChk(1'b1, 1'b0, "R7 fast only");
    srcReq = 32'h0002_0000;
    settle();
    outChk(1'b0, 1'b1, "R7 norm only");
    srcReq = 32'h0000_0002;
    wr(3'd1, 32'h0000_FFFD);
    settle();
    outChk(1'b0, 1'b1, "R7 moved to norm");
    rdChk(3'd5, 32'h0000_0002, "R7 norm pending after move");
    srcReq = '0;
    settle();
  endtask

  task automatic t_mask();
    wr(3'd0, 32'h7FFF_FFFF);
    wr(3'd1, 32'h8000_0000);
    srcReq = 32'h8000_0000;
    settle();
    outChk(1'b0, 1'b0, "R6 disabled source");
    rdChk(3'd4, '0, "R6 fast pending");
    rdChk(3'd3, 32'h8000_0000, "R3 raw shows disabled source");
    srcReq = '0;
    settle();
  endtask

  task automatic t_latency();
    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'h0000_0001);
    settle();
    srcReq = 32'h1;
    #1;
    outChk(1'b0, 1'b0, "R5 before edge");
    @(negedge clk);
    outChk(1'b1, 1'b0, "R5 one edge later");
    srcReq = '0;
    #1;
    outChk(1'b1, 1'b0, "R5 held before edge");
    @(negedge clk);
    outChk(1'b0, 1'b0, "R5 drops one edge later");
  endtask

  task automatic t_wake();
    wr(3'd0, 32'h0000_0001);
    wr(3'd2, 32'h0000_0020);
    wr(3'd6, 32'h0);
    srcReq = 32'h0000_0020;
    settle();
    chk("R8 mode0 disabled source", {{(N-1){1'b0}}, wakeReq}, '0);
    srcReq = 32'h0000_0001;
    settle();
    chk("R8 mode0 enabled source", {{(N-1){1'b0}}, wakeReq}, 32'h1);
    wr(3'd0, '0);
    wr(3'd6, 32'h1);
    srcReq = 32'h0000_0020;
    settle();
    chk("R8 mode1 wake-enabled", {{(N-1){1'b0}}, wakeReq}, 32'h1);
    srcReq = 32'h0000_0001;
    settle();
    chk("R8 mode1 not wake-enabled", {{(N-1){1'b0}}, wakeReq}, '0);
    wr(3'd6, 32'h0);
    srcReq = '0;
    settle();
  endtask

  task automatic t_readonly();
    wr(3'd0, 32'h0000_00F0);
    wr(3'd1, 32'h0000_0030);
    wr(3'd2, 32'h0000_0C00);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rdChk(3'd0, 32'h0000_00F0, "R9 enable kept");
    rdChk(3'd1, 32'h0000_0030, "R9 class kept");
    rdChk(3'd2, 32'h0000_0C00, "R9 wake-enable kept");
    rdChk(3'd6, 32'h0, "R9 mode kept");
    srcReq = 32'h0000_0050;
    settle();
    rdChk(3'd4, 32'h0000_0010, "R9 fast pending unaffected");
    rdChk(3'd5, 32'h0000_0040, "R9 norm pending unaffected");
    rdChk(3'd7, '0, "R10 spare reads zero");
    srcReq = '0;
    settle();
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_raw();
    t_route();
    t_mask();
    t_latency();
    t_wake();
    t_readonly();
    finishRun();
  end

endmodule